// File: doc/BRIEF.md
# Texture Parameter Register Packer

This block takes one decoded texture-fetch operation and works out how its parameters are laid out across two source register groups. The coordinate group holds an array/clamp word and the s, t and r coordinates. The auxiliary group holds a packed resource-pointer word, an LOD value, a texel-offset word and a depth-compare reference. Any parameter that is not present is removed, and the ones after it move up one slot. For each group the block reports which parameters are present, the slot each one occupies, the scalar count and the alignment that count requires.

The block also checks the three register operands: the coordinate base, the auxiliary base and the destination. It flags a base that is misaligned, a zero register used for a group that has parameters, and feature combinations that are not supported. It packs the three offset immediates into one word, and the clamp value and array index into another. An issue stage uses the result to gather operands and to reject illegal operations before they reach the sampler. All results are registered and appear one cycle after a valid input.

Top module: `texparm_packer`

## Requirements
- R1: When `in_valid` is high at a clock edge, every output reflects that operation after the edge and `out_valid` is high for exactly that cycle. When `in_valid` is low, `out_valid` falls and all other outputs hold their values. While reset is held, `out_valid` and every error flag read 0.
- R2: Coordinate group presence `ra_present` is {r, t, s, array word}, from bit 3 down to bit 0. The array word is present when `is_array` or `lod_clamp_en` is set. s is always present. t is present unless `dim` is 1D. r is present for 3D and cube. The `dim` encoding is 0=1D, 1=2D, 2=3D, 3=cube.
- R3: Auxiliary group presence `rb_present` is {depth reference, offset word, LOD, pointer word}, from bit 3 down to bit 0. The pointer word is present when `bindless` is set. LOD is present for `lod_mode` 2 to 7, and modes 0 (none) and 1 (finest level) need no register. The offset word is present when `offset_en` is set, and the depth reference when `dc_en` is set.
- R4: Each present parameter's 2-bit slot, at bits [2i+1:2i] of `*_slots`, equals the number of present parameters below it in the same group. An absent parameter reports slot 0.
- R5: `*_count` is the number of present parameters. The alignment is 1 for a count of 0 or 1, 2 for a count of 2, and 4 for a count of 3 or 4.
- R6: `err_ra_misalign` and `err_rb_misalign` are set when the group has at least one parameter and its base index is not a multiple of the group's alignment.
- R7: `err_ra_zero` and `err_rb_zero` are set when the base index equals the zero register (255) and the group has parameters. A group with no parameters never raises a zero or misalignment error, whatever base index it is given.
- R8: The destination alignment `rd_align` follows the R5 rule, applied to the number of bits set in `wmask`. A mask of 0 is treated as 0xF. `err_rd_misalign` is set when `rd_idx` is not a multiple of `rd_align`.
- R9: `off_word` is {w, v, u}: w in [11:8], v in [7:4] and u in [3:0]. Each field is a 4-bit two's-complement value from -8 to +7. The word is 0 when `offset_en` is clear.
- R10: `ac_word` holds the array index in [15:0]. When `lod_clamp_en` is set it also holds the u4.8 clamp value in [27:16]. All other bits are 0, and the whole word is 0 when the array word is absent.
- R11: `err_cube_offset` flags an offset used with a cube map. `err_3d_compare` flags a depth compare used with a 3D texture. `err_reserved_dim` flags the reserved combination of the array flag with 3D.
- R12: `err_any` is the OR of all eight violation flags.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Decoded operation valid |
| dim | input | 2 | Dimensionality: 0=1D, 1=2D, 2=3D, 3=cube |
| is_array | input | 1 | Array texture |
| lod_clamp_en | input | 1 | LOD clamp supplied with array word |
| bindless | input | 1 | Pointer word supplied in auxiliary group |
| lod_mode | input | 3 | 0 none, 1 finest, 2-7 register-supplied LOD |
| offset_en | input | 1 | Texel offset supplied |
| dc_en | input | 1 | Depth-compare reference supplied |
| off_u | input | 4 | u offset, two's complement |
| off_v | input | 4 | v offset, two's complement |
| off_w | input | 4 | w offset, two's complement |
| lod_clamp | input | 12 | Clamp value, u4.8 |
| array_idx | input | 16 | Array index |
| wmask | input | 4 | Destination write mask (0 means 0xF) |
| rd_idx | input | 8 | Destination base register |
| ra_idx | input | 8 | Coordinate group base register |
| rb_idx | input | 8 | Auxiliary group base register |
| out_valid | output | 1 | Result valid |
| ra_present | output | 4 | Coordinate group presence |
| ra_slots | output | 8 | Coordinate group slots, 2 bits each |
| ra_count | output | 3 | Coordinate group scalar count |
| ra_align | output | 3 | Coordinate group alignment |
| rb_present | output | 4 | Auxiliary group presence |
| rb_slots | output | 8 | Auxiliary group slots, 2 bits each |
| rb_count | output | 3 | Auxiliary group scalar count |
| rb_align | output | 3 | Auxiliary group alignment |
| rd_align | output | 3 | Destination alignment |
| off_word | output | 12 | Packed offsets |
| ac_word | output | 32 | Packed clamp/array word |
| err_ra_misalign | output | 1 | Coordinate base misaligned |
| err_rb_misalign | output | 1 | Auxiliary base misaligned |
| err_rd_misalign | output | 1 | Destination misaligned |
| err_ra_zero | output | 1 | Coordinate group on zero register |
| err_rb_zero | output | 1 | Auxiliary group on zero register |
| err_cube_offset | output | 1 | Offset with cube map |
| err_3d_compare | output | 1 | Depth compare with 3D |
| err_reserved_dim | output | 1 | Array 3D requested |
| err_any | output | 1 | OR of all violations |

## Verification
The block holds no state beyond its output register, so a fault appears at the ports in the first cycle after the operation that provokes it. A wrong compaction shows as a slot that skips or repeats a position, and the slot values then disagree with the counts. A wrong count shows up again as a wrong alignment and as misalignment errors for the wrong base indices. A faulty hold path shows as outputs that change during an idle cycle after a result, and each such cycle is checked.

// File: rtl/texparm_pkg.sv
// Package: shared encodings and the count-to-alignment rule for the packer.
// Assumes groups hold at most four scalars.
package texparm_pkg;

    typedef enum logic [1:0] {
        DIM_1D   = 2'd0,
        DIM_2D   = 2'd1,
        DIM_3D   = 2'd2,
        DIM_CUBE = 2'd3
    } tp_dim_e;

    localparam int unsigned GROUP_SLOTS = 4;

    // Alignment for a scalar count: 0/1 -> 1, 2 -> 2, 3/4 -> 4.
    function automatic logic [2:0] align_for(input logic [2:0] cnt);
        logic [2:0] a;
        case (cnt)
            3'd0, 3'd1: a = 3'd1;
            3'd2:       a = 3'd2;
            default:    a = 3'd4;
        endcase
        return a;
    endfunction

endpackage

// File: rtl/tp_group_layout.sv
// Module: tp_group_layout
// Compacts a presence vector into slot positions and a scalar count.
// Assumes slot width SW can index all N slots and CW can hold N.
module tp_group_layout #(
    parameter int N  = 4,
    parameter int SW = 2,
    parameter int CW = 3
) (
    input  logic [N-1:0]    present,
    output logic [N*SW-1:0] slots,
    output logic [CW-1:0]   count
);

    // Running count of present entries gives each entry its slot.
    always_comb begin
        logic [CW-1:0] run;
        run   = '0;
        slots = '0;
        for (int i = 0; i < N; i++) begin
            if (present[i]) begin
                slots[i*SW +: SW] = run[SW-1:0];
            end
            run = run + CW'(present[i]);
        end
        count = run;
    end

endmodule

// File: rtl/tp_align_check.sv
// Module: tp_align_check
// Derives alignment from a scalar count and checks a base register index.
// Assumes alignment never exceeds 4, so only the two low index bits matter.
module tp_align_check
    import texparm_pkg::*;
#(
    parameter int          REG_W      = 8,
    parameter int          CW         = 3,
    parameter logic [7:0]  ZERO_IDX   = 8'd255,
    parameter bit          CHECK_ZERO = 1'b1
) (
    input  logic [CW-1:0]    count,
    input  logic [REG_W-1:0] idx,
    output logic [2:0]       align,
    output logic             misalign,
    output logic             zero_err
);

    logic [1:0] low_mask;
    logic       used;

    // Alignment and misalignment of the base index.
    always_comb begin
        align    = align_for(3'(count));
        low_mask = align[1:0] - 2'd1;
        used     = (count != '0);
        misalign = used && ((idx[1:0] & low_mask) != 2'd0);
    end

    // Zero-register use is checked only where the variant asks for it.
    generate
        if (CHECK_ZERO) begin : g_zero
            assign zero_err = used && (idx == REG_W'(ZERO_IDX));
        end else begin : g_nozero
            assign zero_err = 1'b0;
        end
    endgenerate

endmodule

// File: rtl/texparm_packer.sv
// Module: texparm_packer (top)
// Lays out texture-fetch parameters in two register groups, checks the
// operand registers, packs offset and clamp/array words. Results are
// registered one cycle after in_valid and held while in_valid is low.
// Assumes four slots per group and a single zero-register index.
module texparm_packer
    import texparm_pkg::*;
#(
    parameter int         REG_W    = 8,
    parameter logic [7:0] ZERO_IDX = 8'd255,
    parameter int         OFF_W    = 4,
    parameter int         CLAMP_W  = 12,
    parameter int         ARR_W    = 16,
    parameter int         AC_W     = 32
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               in_valid,
    input  logic [1:0]         dim,
    input  logic               is_array,
    input  logic               lod_clamp_en,
    input  logic               bindless,
    input  logic [2:0]         lod_mode,
    input  logic               offset_en,
    input  logic               dc_en,
    input  logic [OFF_W-1:0]   off_u,
    input  logic [OFF_W-1:0]   off_v,
    input  logic [OFF_W-1:0]   off_w,
    input  logic [CLAMP_W-1:0] lod_clamp,
    input  logic [ARR_W-1:0]   array_idx,
    input  logic [3:0]         wmask,
    input  logic [REG_W-1:0]   rd_idx,
    input  logic [REG_W-1:0]   ra_idx,
    input  logic [REG_W-1:0]   rb_idx,
    output logic               out_valid,
    output logic [3:0]         ra_present,
    output logic [7:0]         ra_slots,
    output logic [2:0]         ra_count,
    output logic [2:0]         ra_align,
    output logic [3:0]         rb_present,
    output logic [7:0]         rb_slots,
    output logic [2:0]         rb_count,
    output logic [2:0]         rb_align,
    output logic [2:0]         rd_align,
    output logic [3*OFF_W-1:0] off_word,
    output logic [AC_W-1:0]    ac_word,
    output logic               err_ra_misalign,
    output logic               err_rb_misalign,
    output logic               err_rd_misalign,
    output logic               err_ra_zero,
    output logic               err_rb_zero,
    output logic               err_cube_offset,
    output logic               err_3d_compare,
    output logic               err_reserved_dim,
    output logic               err_any
);

    localparam int N      = GROUP_SLOTS;
    localparam int SW     = $clog2(N);
    localparam int CW     = $clog2(N + 1);
    localparam int AC_PAD = AC_W - CLAMP_W - ARR_W;

    tp_dim_e             dim_e;
    logic [N-1:0]        ra_pres_c, rb_pres_c;
    logic [N*SW-1:0]     ra_slots_c, rb_slots_c;
    logic [CW-1:0]       ra_cnt_c, rb_cnt_c, wm_cnt_c;
    logic [2:0]          ra_al_c, rb_al_c, rd_al_c;
    logic                ra_mis_c, rb_mis_c, rd_mis_c;
    logic                ra_zero_c, rb_zero_c, rd_zero_unused;
    logic [3:0]          wm_eff;
    logic [3*OFF_W-1:0]  off_c;
    logic [AC_W-1:0]     ac_c;
    logic                cube_off_c, dc3d_c, rsv_c;

    // Decode which parameters each group carries.
    always_comb begin
        dim_e     = tp_dim_e'(dim);
        ra_pres_c = {(dim_e == DIM_3D) || (dim_e == DIM_CUBE),
                     dim_e != DIM_1D,
                     1'b1,
                     is_array | lod_clamp_en};
        rb_pres_c = {dc_en, offset_en, lod_mode >= 3'd2, bindless};
    end

    // Destination component count, with an empty mask meaning all four.
    always_comb begin
        wm_eff   = (wmask == 4'd0) ? 4'hF : wmask;
        wm_cnt_c = CW'($countones(wm_eff));
    end

    // Immediate word packing and unsupported-combination flags.
    always_comb begin
        off_c      = offset_en ? {off_w, off_v, off_u} : '0;
        if (!ra_pres_c[0])
            ac_c = '0;
        else if (lod_clamp_en)
            ac_c = {{AC_PAD{1'b0}}, lod_clamp, array_idx};
        else
            ac_c = {{(AC_W-ARR_W){1'b0}}, array_idx};
        cube_off_c = offset_en && (dim_e == DIM_CUBE);
        dc3d_c     = dc_en && (dim_e == DIM_3D);
        rsv_c      = is_array && (dim_e == DIM_3D);
    end

    tp_group_layout #(.N(N), .SW(SW), .CW(CW)) u_ra_layout (
        .present(ra_pres_c), .slots(ra_slots_c), .count(ra_cnt_c));

    tp_group_layout #(.N(N), .SW(SW), .CW(CW)) u_rb_layout (
        .present(rb_pres_c), .slots(rb_slots_c), .count(rb_cnt_c));

    tp_align_check #(.REG_W(REG_W), .CW(CW), .ZERO_IDX(ZERO_IDX), .CHECK_ZERO(1'b1)) u_ra_chk (
        .count(ra_cnt_c), .idx(ra_idx), .align(ra_al_c), .misalign(ra_mis_c), .zero_err(ra_zero_c));

    tp_align_check #(.REG_W(REG_W), .CW(CW), .ZERO_IDX(ZERO_IDX), .CHECK_ZERO(1'b1)) u_rb_chk (
        .count(rb_cnt_c), .idx(rb_idx), .align(rb_al_c), .misalign(rb_mis_c), .zero_err(rb_zero_c));

    tp_align_check #(.REG_W(REG_W), .CW(CW), .ZERO_IDX(ZERO_IDX), .CHECK_ZERO(1'b0)) u_rd_chk (
        .count(wm_cnt_c), .idx(rd_idx), .align(rd_al_c), .misalign(rd_mis_c), .zero_err(rd_zero_unused));

    // Output register: load on in_valid, hold otherwise, clear on reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid        <= 1'b0;
            ra_present       <= '0;
            ra_slots         <= '0;
            ra_count         <= '0;
            ra_align         <= 3'd1;
            rb_present       <= '0;
            rb_slots         <= '0;
            rb_count         <= '0;
            rb_align         <= 3'd1;
            rd_align         <= 3'd1;
            off_word         <= '0;
            ac_word          <= '0;
            err_ra_misalign  <= 1'b0;
            err_rb_misalign  <= 1'b0;
            err_rd_misalign  <= 1'b0;
            err_ra_zero      <= 1'b0;
            err_rb_zero      <= 1'b0;
            err_cube_offset  <= 1'b0;
            err_3d_compare   <= 1'b0;
            err_reserved_dim <= 1'b0;
            err_any          <= 1'b0;
        end else begin
            out_valid <= in_valid;
            if (in_valid) begin
                ra_present       <= ra_pres_c;
                ra_slots         <= ra_slots_c;
                ra_count         <= 3'(ra_cnt_c);
                ra_align         <= ra_al_c;
                rb_present       <= rb_pres_c;
                rb_slots         <= rb_slots_c;
                rb_count         <= 3'(rb_cnt_c);
                rb_align         <= rb_al_c;
                rd_align         <= rd_al_c;
                off_word         <= off_c;
                ac_word          <= ac_c;
                err_ra_misalign  <= ra_mis_c;
                err_rb_misalign  <= rb_mis_c;
                err_rd_misalign  <= rd_mis_c;
                err_ra_zero      <= ra_zero_c;
                err_rb_zero      <= rb_zero_c;
                err_cube_offset  <= cube_off_c;
                err_3d_compare   <= dc3d_c;
                err_reserved_dim <= rsv_c;
                err_any          <= ra_mis_c | rb_mis_c | rd_mis_c | ra_zero_c |
                                    rb_zero_c | cube_off_c | dc3d_c | rsv_c;
            end
        end
    end

endmodule

// File: rtl/texparm_packer_chk.sv
// Module: texparm_packer_chk
// Temporal checks on the packer ports, attached through bind.
// Assumes the default four-slot, 8-bit-index configuration.
module texparm_packer_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       in_valid,
    input logic       out_valid,
    input logic [3:0] ra_present,
    input logic [2:0] ra_count,
    input logic [2:0] ra_align,
    input logic [3:0] rb_present,
    input logic [7:0] rb_slots,
    input logic [2:0] rb_count,
    input logic [2:0] rb_align,
    input logic [11:0] off_word,
    input logic [31:0] ac_word,
    input logic       err_rb_misalign,
    input logic       err_ra_zero,
    input logic       err_rb_zero,
    input logic       err_any
);

    AST_VALID_PIPE: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid); // R1
    AST_VALID_DROP: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid); // R1
    AST_HOLD_WORDS: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && !in_valid |=> $stable(ac_word) && $stable(ra_present)); // R1
    AST_RA_HAS_S: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> ra_present[1] && ra_count != 3'd0); // R2
    AST_SLOT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && rb_present[3] |-> {1'b0, rb_slots[7:6]} < rb_count); // R4
    AST_ALIGN_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> $onehot0(ra_align) && ra_align != 3'd0 && $onehot0(rb_align)); // R5
    AST_EMPTY_NO_ERR: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && rb_count == 3'd0 |-> !err_rb_zero && !err_rb_misalign); // R7
    AST_OFF_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && !rb_present[2] |-> off_word == 12'd0); // R9
    AST_ERR_ANY: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && (err_ra_zero || err_rb_zero) |-> err_any); // R12

endmodule

bind texparm_packer texparm_packer_chk u_chk (.*);

// File: tb/tb_texparm_packer.sv
module tb_texparm_packer;
    localparam int CLK_PERIOD = 10;

    logic clk = 1'b0, rst_n = 1'b0, in_valid = 1'b0;
    logic [1:0] dim = '0; logic is_array = 0, lod_clamp_en = 0, bindless = 0;
    logic [2:0] lod_mode = '0; logic offset_en = 0, dc_en = 0;
    logic [3:0] off_u = '0, off_v = '0, off_w = '0;
    logic [11:0] lod_clamp = '0; logic [15:0] array_idx = '0;
    logic [3:0] wmask = '0; logic [7:0] rd_idx = '0, ra_idx = '0, rb_idx = '0;

    logic out_valid; logic [3:0] ra_present, rb_present; logic [7:0] ra_slots, rb_slots;
    logic [2:0] ra_count, ra_align, rb_count, rb_align, rd_align;
    logic [11:0] off_word; logic [31:0] ac_word;
    logic err_ra_misalign, err_rb_misalign, err_rd_misalign, err_ra_zero, err_rb_zero;
    logic err_cube_offset, err_3d_compare, err_reserved_dim, err_any;

    int n_chk = 0, n_fail = 0;
    bit done = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    texparm_packer dut (.*);

    // Expected values, computed from the requirements.
    logic [3:0] e_rap, e_rbp; logic [7:0] e_ras, e_rbs; logic [2:0] e_rac, e_raa, e_rbc, e_rba, e_rda;
    logic [11:0] e_off; logic [31:0] e_ac; logic [8:0] e_err; // {any,rsv,dc3d,cube,rbz,raz,rdm,rbm,ram}

    function automatic logic [2:0] al(input int c);
        return (c <= 1) ? 3'd1 : (c == 2) ? 3'd2 : 3'd4;
    endfunction

    task automatic layout(input logic [3:0] p, output logic [7:0] s, output logic [2:0] c);
        int k = 0; s = '0;
        for (int i = 0; i < 4; i++) if (p[i]) begin s[2*i +: 2] = 2'(k); k++; end
        c = 3'(k);
    endtask

    task automatic model();
        int wc; logic [3:0] wm;
        e_rap = {dim >= 2'd2, dim != 2'd0, 1'b1, is_array | lod_clamp_en};   // R2
        e_rbp = {dc_en, offset_en, lod_mode >= 3'd2, bindless};              // R3
        layout(e_rap, e_ras, e_rac); layout(e_rbp, e_rbs, e_rbc);           // R4
        e_raa = al(e_rac); e_rba = al(e_rbc);                                // R5
        wm = (wmask == 0) ? 4'hF : wmask; wc = $countones(wm); e_rda = al(wc); // R8
        e_off = offset_en ? {off_w, off_v, off_u} : 12'd0;                   // R9
        e_ac = !e_rap[0] ? 32'd0 : lod_clamp_en ? {4'd0, lod_clamp, array_idx} : {16'd0, array_idx}; // R10
        e_err = '0;
        e_err[0] = (e_rac != 0) && (ra_idx % e_raa != 0);                    // R6
        e_err[1] = (e_rbc != 0) && (rb_idx % e_rba != 0);
        e_err[2] = (rd_idx % e_rda != 0);
        e_err[3] = (e_rac != 0) && (ra_idx == 8'd255);                       // R7
        e_err[4] = (e_rbc != 0) && (rb_idx == 8'd255);
        e_err[5] = offset_en && dim == 2'd3;                                 // R11
        e_err[6] = dc_en && dim == 2'd2;
        e_err[7] = is_array && dim == 2'd2;
        e_err[8] = |e_err[7:0];                                              // R12
    endtask

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    task automatic check_all(input logic ev);
        logic [8:0] a_err;
        a_err = {err_any, err_reserved_dim, err_3d_compare, err_cube_offset, err_rb_zero,
                 err_ra_zero, err_rd_misalign, err_rb_misalign, err_ra_misalign};
        chk("R1 out_valid", 32'(out_valid), 32'(ev));
        chk("R2 ra_present", 32'(ra_present), 32'(e_rap));
        chk("R3 rb_present", 32'(rb_present), 32'(e_rbp));
        chk("R4 ra_slots", 32'(ra_slots), 32'(e_ras));
        chk("R4 rb_slots", 32'(rb_slots), 32'(e_rbs));
        chk("R5 counts", {ra_count, ra_align, rb_count, rb_align}, {e_rac, e_raa, e_rbc, e_rba});
        chk("R8 rd_align", 32'(rd_align), 32'(e_rda));
        chk("R9 off_word", 32'(off_word), 32'(e_off));
        chk("R10 ac_word", ac_word, e_ac);
        chk("R6 R7 R11 R12 errors", 32'(a_err), 32'(e_err));
    endtask

    // One operation: drive, check after the edge, then an idle cycle for hold.
    task automatic apply();
        @(negedge clk); in_valid = 1'b1; model();
        @(negedge clk); in_valid = 1'b0; check_all(1'b1);
        off_u = 4'($urandom); array_idx = 16'($urandom); ra_idx = 8'($urandom);
        @(negedge clk); check_all(1'b0);                                     // R1 hold
    endtask

    task automatic rand_op();
        dim = 2'($urandom); is_array = 1'($urandom); lod_clamp_en = 1'($urandom);
        bindless = 1'($urandom); lod_mode = 3'($urandom); offset_en = 1'($urandom);
        dc_en = 1'($urandom); off_u = 4'($urandom); off_v = 4'($urandom); off_w = 4'($urandom);
        lod_clamp = 12'($urandom); array_idx = 16'($urandom); wmask = 4'($urandom);
        rd_idx = ($urandom % 4 == 0) ? 8'($urandom % 16 * 4) : 8'($urandom);
        ra_idx = ($urandom % 5 == 0) ? 8'd255 : 8'($urandom);
        rb_idx = ($urandom % 5 == 0) ? 8'd255 : 8'($urandom % 64 * 4);
    endtask

    initial begin
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        // Reset state (R1)
        chk("R1 reset out_valid", 32'(out_valid), 0);
        chk("R1 reset err_any", 32'(err_any), 0);
        @(negedge clk); rst_n = 1'b1;

        // Minimal op, nothing in aux group, rb on zero register: tolerated (R7)
        dim = 0; rb_idx = 8'd255; ra_idx = 8'd3; rd_idx = 8'd4; wmask = 4'd0;
        apply();
        // Full aux group, cube + offset + array (R3, R11)
        dim = 3; is_array = 1; bindless = 1; lod_mode = 3'd2; offset_en = 1; dc_en = 1;
        off_u = 4'h8; off_v = 4'h7; off_w = 4'hF; ra_idx = 8'd8; rb_idx = 8'd12; rd_idx = 8'd2;
        apply();
        // Array 3D reserved, depth with 3D, clamp word (R10, R11)
        dim = 2; lod_clamp_en = 1; lod_clamp = 12'hABC; array_idx = 16'h1234; lod_mode = 3'd1;
        bindless = 0; offset_en = 0; ra_idx = 8'd255; rb_idx = 8'd255; wmask = 4'b0011; rd_idx = 8'd6;
        apply();
        // Two-scalar coordinate group, three-component destination (R5, R8)
        dim = 1; is_array = 0; lod_clamp_en = 0; dc_en = 0; ra_idx = 8'd2; rb_idx = 8'd0;
        wmask = 4'b0111; rd_idx = 8'd2;
        apply();

        for (int i = 0; i < 400; i++) begin
            rand_op();
            apply();
        end
        done = 1;
    end

    initial begin : watchdog
        fork
            wait (done);
            begin
                repeat (20000) @(posedge clk);
                n_chk++; n_fail++;
                $display("FAIL watchdog actual=timeout expected=completion");
            end
        join_any
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end
endmodule